// File: doc/BRIEF.md
# Configuration Security Policy Controller

This block sits next to a device configuration engine and decides, cycle by cycle, which image loads are allowed, whether configuration memory may be read back, and how the device reports a failed or dangerous load. It does not decrypt or check images. It sees abstract events: a power-on reset, a program-pin pulse and a program command, each of which clears configuration memory. It also sees load requests tagged with a kind (full, partial, fallback, internal reprogram), an encryption flag and a key-compare result from the decryption datapath.

The controller records whether the loaded image arrived encrypted or in plain form. It grants readback only for plain images, and only when the separate readback setting allows it. It refuses a second full image until memory is cleared. Partial images must carry the same encryption option as the loaded image, while fallback and internal-reprogram images may carry either option. A key mismatch leaves DONE low and can trigger a timed INIT_B low pulse followed by a request for the fallback image. An encrypted load that names the battery-backed key before that key has been stored locks the block until the next power-on reset. The key-stored flag lives in the battery domain, and only its own supply-loss reset clears it.

Top module: `cfg_sec_policy`

## Requirements
- R1: After power-on reset, DONE, accept, reject, readback permission, lock and fallback request are all 0 and INIT_B is 1.
- R2: Every cycle with a load request is followed one cycle later by exactly one of accept or reject, each lasting one cycle. A cycle without a request produces neither.
- R3: After an accepted encrypted load, readback permission is 0 whatever the readback setting is.
- R4: After an accepted plain full, fallback or internal-reprogram load, readback permission follows the readback setting.
- R5: While a key is held (fused key present or battery key stored), a plain full image is accepted only if memory was last cleared by power-on reset or the program pin, and not by the program command. The key-compare result is ignored for plain images.
- R6: Once the device is configured, a full image is rejected until a program-pin pulse, a program command or a power-on reset occurs. After any of these, DONE is 0.
- R7: Fallback (kind 2) and internal-reprogram (kind 3) loads are accepted in any unlocked state with either encryption option, and the new image's option sets the readback rule.
- R8: A partial load (kind 1) is accepted only when its encryption flag equals that of the loaded image. Otherwise it is rejected, and in both cases DONE and readback permission keep their values.
- R9: An encrypted load with a key mismatch is rejected and leaves DONE at 0. With fallback enabled, INIT_B goes low for INIT_LOW_CYC cycles (default 4), and fallback request pulses for one cycle in the cycle where INIT_B returns high.
- R10: With fallback disabled, a key mismatch holds INIT_B low until a program event or power-on reset.
- R11: An encrypted load with the battery key selected while no battery key is stored sets lock. While locked, every request is rejected, DONE and readback permission are 0, program pin and command have no effect, and only power-on reset clears lock.
- R12: The battery-key-stored flag is set by the key-store strobe and cleared only by the battery-domain reset. Power-on reset and program events leave it unchanged.
- R13: A program event in the same cycle as a request wins: the request is rejected and the device becomes unconfigured.
- R14: Full image is kind 0. The full-load rule is checked before the key compare, so a refused full image never causes a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bat_rst_n | input | 1 | Battery-domain reset (battery and auxiliary supply lost), active low |
| prog_pin_i | input | 1 | Program-pin pulse, clears configuration memory |
| prog_cmd_i | input | 1 | Program command, clears configuration memory |
| key_store_i | input | 1 | Strobe: battery-backed key has been written |
| otp_key_i | input | 1 | A fused key is present |
| key_src_bat_i | input | 1 | Encrypted loads use the battery-backed key |
| rb_allow_i | input | 1 | Readback security setting allows readback |
| fb_en_i | input | 1 | Fallback on failure enabled |
| req_valid_i | input | 1 | Load request strobe |
| req_kind_i | input | 2 | 0 full, 1 partial, 2 fallback, 3 internal reprogram |
| req_enc_i | input | 1 | Requested image is encrypted |
| key_match_i | input | 1 | Image key equals stored key |
| accept_o | output | 1 | Request accepted (one-cycle pulse) |
| reject_o | output | 1 | Request rejected (one-cycle pulse) |
| done_o | output | 1 | Device configured |
| init_b_o | output | 1 | INIT_B level, low during a failure indication |
| fallback_req_o | output | 1 | One-cycle request to fetch the fallback image |
| readback_ok_o | output | 1 | Configuration readback permitted |
| locked_o | output | 1 | Lock-up condition |

## Verification
A wrong recorded encryption option shows at the ports one cycle after the load, as a readback permission that disobeys the readback setting or as a partial image accepted with the wrong option. A lost memory-cleared marker shows on the next plain full request as the wrong accept or reject pulse. A timer fault shows as an INIT_B low window of the wrong length or a misplaced fallback request. A lock that fails to stick shows as an accept or a DONE rise after a program pulse.

// File: rtl/csp_pkg.sv
package csp_pkg;

    typedef enum logic [2:0] {
        ST_BLANK     = 3'd0,
        ST_CFG_ENC   = 3'd1,
        ST_CFG_PLAIN = 3'd2,
        ST_FAILED    = 3'd3,
        ST_LOCKED    = 3'd4
    } csp_state_e;

    typedef enum logic [1:0] {
        LD_FULL     = 2'd0,
        LD_PARTIAL  = 2'd1,
        LD_FALLBACK = 2'd2,
        LD_IPROG    = 2'd3
    } csp_kind_e;

    typedef struct packed {
        logic       accept;
        logic       reject;
        csp_state_e nxt_state;
        logic       fail_pulse;
        logic       fail_hold;
        logic       loaded;
    } csp_verdict_t;

endpackage

// File: rtl/csp_decide.sv
module csp_decide
    import csp_pkg::*;
(
    input  csp_state_e   state_i,
    input  logic         prog_evt_i,
    input  logic         req_valid_i,
    input  csp_kind_e    req_kind_i,
    input  logic         req_enc_i,
    input  logic         key_match_i,
    input  logic         key_src_bat_i,
    input  logic         bat_key_i,
    input  logic         otp_key_i,
    input  logic         pin_cleared_i,
    input  logic         fb_en_i,
    output csp_verdict_t verdict_o
);

    logic key_held;
    logic kind_ok;

    assign key_held = otp_key_i | bat_key_i;

    // Kind rules: full images only into blank memory (R6, R5),
    // partial images must match the loaded option (R8),
    // fallback and internal reprogram take either option (R7).
    always_comb begin
        unique case (req_kind_i)
            LD_FULL:    kind_ok = (state_i == ST_BLANK) &&
                                  (req_enc_i || !key_held || pin_cleared_i);
            LD_PARTIAL: kind_ok = ((state_i == ST_CFG_ENC)   &&  req_enc_i) ||
                                  ((state_i == ST_CFG_PLAIN) && !req_enc_i);
            default:    kind_ok = 1'b1;
        endcase
    end

    always_comb begin
        verdict_o            = '0;
        verdict_o.nxt_state  = state_i;
        if (prog_evt_i) begin
            // R13: a program event outranks a request in the same cycle
            if (state_i != ST_LOCKED) verdict_o.nxt_state = ST_BLANK;
            verdict_o.reject = req_valid_i;
        end else if (req_valid_i) begin
            if (state_i == ST_LOCKED) begin
                verdict_o.reject = 1'b1;
            end else if (req_enc_i && key_src_bat_i && !bat_key_i) begin
                verdict_o.reject    = 1'b1;
                verdict_o.nxt_state = ST_LOCKED;
            end else if (!kind_ok) begin
                verdict_o.reject = 1'b1;
            end else if (req_enc_i && !key_match_i) begin
                verdict_o.reject     = 1'b1;
                verdict_o.nxt_state  = ST_FAILED;
                verdict_o.fail_pulse = fb_en_i;
                verdict_o.fail_hold  = !fb_en_i;
                verdict_o.loaded     = 1'b1;
            end else begin
                verdict_o.accept = 1'b1;
                if (req_kind_i != LD_PARTIAL) begin
                    verdict_o.nxt_state = req_enc_i ? ST_CFG_ENC : ST_CFG_PLAIN;
                    verdict_o.loaded    = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/csp_init_timer.sv
module csp_init_timer #(
    parameter int INIT_LOW_CYC = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear_i,
    input  logic start_i,
    input  logic hold_i,
    output logic init_b_o,
    output logic fallback_req_o
);

    localparam int CNT_W = $clog2(INIT_LOW_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hold;
        logic             fb;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        tmr_d.fb = 1'b0;
        if (clear_i) begin
            tmr_d = '0;
        end else if (start_i) begin
            tmr_d.cnt  = CNT_W'(INIT_LOW_CYC);
            tmr_d.hold = 1'b0;
        end else if (hold_i) begin
            tmr_d.cnt  = '0;
            tmr_d.hold = 1'b1;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
            tmr_d.fb  = (tmr_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign init_b_o       = (tmr_q.cnt == '0) && !tmr_q.hold;
    assign fallback_req_o = tmr_q.fb;

    AST_FB_AT_RISE: assert property (@(posedge clk) disable iff (!por_n)
        fallback_req_o |-> (init_b_o && $past(!init_b_o))); // R9

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!por_n)
        (!init_b_o && tmr_q.hold && !clear_i && !start_i) |=> !init_b_o); // R10

endmodule

// File: rtl/csp_readback_gate.sv
module csp_readback_gate
    import csp_pkg::*;
(
    input  csp_state_e state_i,
    input  logic       rb_allow_i,
    output logic       readback_ok_o
);

    // Only a plain image opens the readback path, and then only if allowed.
    always_comb begin
        unique case (state_i)
            ST_CFG_PLAIN: readback_ok_o = rb_allow_i;
            default:      readback_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_sec_policy.sv
module cfg_sec_policy
    import csp_pkg::*;
#(
    parameter int INIT_LOW_CYC = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       bat_rst_n,
    input  logic       prog_pin_i,
    input  logic       prog_cmd_i,
    input  logic       key_store_i,
    input  logic       otp_key_i,
    input  logic       key_src_bat_i,
    input  logic       rb_allow_i,
    input  logic       fb_en_i,
    input  logic       req_valid_i,
    input  logic [1:0] req_kind_i,
    input  logic       req_enc_i,
    input  logic       key_match_i,
    output logic       accept_o,
    output logic       reject_o,
    output logic       done_o,
    output logic       init_b_o,
    output logic       fallback_req_o,
    output logic       readback_ok_o,
    output logic       locked_o
);

    typedef struct packed {
        csp_state_e state;
        logic       accept;
        logic       reject;
        logic       pin_cleared;
    } pol_t;

    pol_t         pol_d, pol_q;
    logic         bat_key_d, bat_key_q;
    logic         prog_evt;
    csp_verdict_t verdict;

    assign prog_evt = prog_pin_i | prog_cmd_i;

    csp_decide u_decide (
        .state_i       (pol_q.state),
        .prog_evt_i    (prog_evt),
        .req_valid_i   (req_valid_i),
        .req_kind_i    (csp_kind_e'(req_kind_i)),
        .req_enc_i     (req_enc_i),
        .key_match_i   (key_match_i),
        .key_src_bat_i (key_src_bat_i),
        .bat_key_i     (bat_key_q),
        .otp_key_i     (otp_key_i),
        .pin_cleared_i (pol_q.pin_cleared),
        .fb_en_i       (fb_en_i),
        .verdict_o     (verdict)
    );

    always_comb begin
        pol_d        = pol_q;
        pol_d.state  = verdict.nxt_state;
        pol_d.accept = verdict.accept;
        pol_d.reject = verdict.reject;
        if (pol_q.state != ST_LOCKED) begin
            if (prog_pin_i)          pol_d.pin_cleared = 1'b1;
            else if (prog_cmd_i)     pol_d.pin_cleared = 1'b0;
            else if (verdict.loaded) pol_d.pin_cleared = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pol_q.state       <= ST_BLANK;
            pol_q.accept      <= 1'b0;
            pol_q.reject      <= 1'b0;
            pol_q.pin_cleared <= 1'b1;
        end else begin
            pol_q <= pol_d;
        end
    end

    // Battery domain: only its own supply-loss reset clears the flag (R12)
    always_comb begin
        bat_key_d = bat_key_q | key_store_i;
    end

    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n) bat_key_q <= 1'b0;
        else            bat_key_q <= bat_key_d;
    end

    csp_init_timer #(.INIT_LOW_CYC(INIT_LOW_CYC)) u_timer (
        .clk            (clk),
        .por_n          (por_n),
        .clear_i        (prog_evt && (pol_q.state != ST_LOCKED)),
        .start_i        (verdict.fail_pulse),
        .hold_i         (verdict.fail_hold),
        .init_b_o       (init_b_o),
        .fallback_req_o (fallback_req_o)
    );

    csp_readback_gate u_rb (
        .state_i       (pol_q.state),
        .rb_allow_i    (rb_allow_i),
        .readback_ok_o (readback_ok_o)
    );

    assign accept_o = pol_q.accept;
    assign reject_o = pol_q.reject;
    assign done_o   = (pol_q.state == ST_CFG_ENC) || (pol_q.state == ST_CFG_PLAIN);
    assign locked_o = (pol_q.state == ST_LOCKED);

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!por_n)
        req_valid_i |=> (accept_o ^ reject_o)); // R2

    AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!por_n)
        !req_valid_i |=> (!accept_o && !reject_o)); // R2

    AST_ENC_NO_READBACK: assert property (@(posedge clk) disable iff (!por_n)
        (accept_o && $past(req_enc_i) && ($past(req_kind_i) != 2'd1)) |-> !readback_ok_o); // R3

    AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!por_n)
        locked_o |=> (locked_o && !accept_o && !done_o)); // R11

    AST_PARTIAL_KEEPS_DONE: assert property (@(posedge clk) disable iff (!por_n)
        (req_valid_i && !prog_evt && req_kind_i == 2'd1 && done_o) |=> done_o); // R8

    AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (prog_evt && !locked_o) |=> (!done_o && !accept_o)); // R13

endmodule

// File: tb/cfg_sec_policy_tb_top.sv
module cfg_sec_policy_tb_top;

    logic       clk = 1'b0;
    logic       por_n, bat_rst_n;
    logic       prog_pin, prog_cmd, key_store, otp_key, key_src_bat;
    logic       rb_allow, fb_en, req_valid, req_enc, key_match;
    logic [1:0] req_kind;
    logic       accept, reject, done, init_b, fb_req, rb_ok, locked;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cfg_sec_policy #(.INIT_LOW_CYC(4)) dut_i (
        .clk(clk), .por_n(por_n), .bat_rst_n(bat_rst_n),
        .prog_pin_i(prog_pin), .prog_cmd_i(prog_cmd), .key_store_i(key_store),
        .otp_key_i(otp_key), .key_src_bat_i(key_src_bat), .rb_allow_i(rb_allow),
        .fb_en_i(fb_en), .req_valid_i(req_valid), .req_kind_i(req_kind),
        .req_enc_i(req_enc), .key_match_i(key_match),
        .accept_o(accept), .reject_o(reject), .done_o(done), .init_b_o(init_b),
        .fallback_req_o(fb_req), .readback_ok_o(rb_ok), .locked_o(locked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic por();
        @(negedge clk);
        por_n = 1'b0; prog_pin = 0; prog_cmd = 0; key_store = 0;
        req_valid = 0; req_kind = 0; req_enc = 0; key_match = 0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one request for one cycle; returns at the cycle its verdict shows.
    task automatic load(input logic [1:0] kind, input logic enc, input logic match);
        @(negedge clk);
        req_valid = 1; req_kind = kind; req_enc = enc; key_match = match;
        @(negedge clk);
        req_valid = 0; req_enc = 0; key_match = 0; req_kind = 0;
    endtask

    task automatic pin();
        @(negedge clk); prog_pin = 1; @(negedge clk); prog_pin = 0;
    endtask

    task automatic cmd();
        @(negedge clk); prog_cmd = 1; @(negedge clk); prog_cmd = 0;
    endtask

    task automatic t_reset();
        bat_rst_n = 0; otp_key = 0; key_src_bat = 0; rb_allow = 1; fb_en = 1;
        por();
        bat_rst_n = 1;
        chk("R1 done", done, 0);
        chk("R1 accept|reject", accept | reject, 0);
        chk("R1 init_b", init_b, 1);
        chk("R1 readback", rb_ok, 0);
        chk("R1 locked|fb_req", locked | fb_req, 0);
        @(negedge clk);
        chk("R2 idle no verdict", accept | reject, 0);
    endtask

    task automatic t_plain_path();
        otp_key = 0; rb_allow = 1; por();
        load(2'd0, 0, 0);
        chk("R2 plain full accept", accept, 1);
        chk("R2 single verdict", reject, 0);
        chk("R4 done", done, 1);
        chk("R4 readback allowed", rb_ok, 1);
        rb_allow = 0; #1;
        chk("R4 readback follows setting", rb_ok, 0);
        rb_allow = 1;
        @(negedge clk);
        chk("R2 pulse one cycle", accept, 0);
        load(2'd0, 0, 0);
        chk("R6 second full rejected", reject, 1);
        chk("R14 refused full no fail", init_b, 1);
        load(2'd1, 0, 0);
        chk("R8 partial plain on plain", accept, 1);
        chk("R8 done kept", done, 1);
        load(2'd1, 1, 1);
        chk("R8 partial enc on plain", reject, 1);
        chk("R8 readback kept", rb_ok, 1);
    endtask

    task automatic t_enc_path();
        otp_key = 1; rb_allow = 1; por();
        load(2'd0, 1, 1);
        chk("R3 enc full accept", accept, 1);
        chk("R3 no readback", rb_ok, 0);
        load(2'd1, 0, 0);
        chk("R8 partial plain on enc", reject, 1);
        load(2'd1, 1, 1);
        chk("R8 partial enc on enc", accept, 1);
        load(2'd2, 0, 0);
        chk("R7 plain fallback accepted", accept, 1);
        chk("R7 readback after plain fallback", rb_ok, 1);
        load(2'd3, 1, 1);
        chk("R7 enc iprog accepted", accept, 1);
        chk("R7 readback after enc iprog", rb_ok, 0);
        chk("R7 done", done, 1);
    endtask

    task automatic t_program_paths();
        otp_key = 1; rb_allow = 1; por();
        load(2'd0, 1, 1);
        cmd();
        chk("R6 cmd clears done", done, 0);
        load(2'd0, 0, 1);
        chk("R5 plain full after cmd with key", reject, 1);
        load(2'd0, 1, 1);
        chk("R6 enc full after cmd", accept, 1);
        pin();
        chk("R6 pin clears done", done, 0);
        load(2'd0, 0, 0);
        chk("R5 plain full after pin, key ignored", accept, 1);
        chk("R5 readback", rb_ok, 1);
    endtask

    task automatic t_mismatch_fb();
        int n;
        otp_key = 1; fb_en = 1; por();
        load(2'd0, 1, 0);
        chk("R9 mismatch rejected", reject, 1);
        chk("R9 done low", done, 0);
        n = 0;
        while (!init_b && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk("R9 init_b low cycles", n, 4);
        chk("R9 fallback req at rise", fb_req, 1);
        @(negedge clk);
        chk("R9 fallback req one cycle", fb_req, 0);
        load(2'd2, 0, 0);
        chk("R7 fallback after failure", accept, 1);
        chk("R7 done after fallback", done, 1);
    endtask

    task automatic t_mismatch_hold();
        otp_key = 1; fb_en = 0; por();
        load(2'd0, 1, 0);
        chk("R10 mismatch rejected", reject, 1);
        repeat (10) @(negedge clk);
        chk("R10 init_b held low", init_b, 0);
        chk("R10 no fallback req", fb_req, 0);
        pin();
        chk("R10 init_b released by pin", init_b, 1);
        fb_en = 1;
    endtask

    task automatic t_lock();
        otp_key = 0; key_src_bat = 1; bat_rst_n = 0; @(negedge clk); bat_rst_n = 1;
        por();
        load(2'd0, 1, 1);
        chk("R11 rejected", reject, 1);
        chk("R11 locked", locked, 1);
        pin(); cmd();
        chk("R11 program ignored", locked, 1);
        load(2'd2, 0, 0);
        chk("R11 fallback rejected", reject, 1);
        chk("R11 done low", done, 0);
        rb_allow = 1; #1;
        chk("R11 readback low", rb_ok, 0);
        por();
        chk("R11 por unlocks", locked, 0);
        key_src_bat = 0;
    endtask

    task automatic t_key_status();
        key_src_bat = 1; otp_key = 0;
        @(negedge clk); key_store = 1; @(negedge clk); key_store = 0;
        pin(); cmd(); por();
        load(2'd0, 1, 1);
        chk("R12 key kept over program/por", accept, 1);
        chk("R12 not locked", locked, 0);
        @(negedge clk); bat_rst_n = 0; @(negedge clk); bat_rst_n = 1;
        por();
        load(2'd0, 1, 1);
        chk("R12 supply loss clears key", locked, 1);
        key_src_bat = 0;
        por();
    endtask

    task automatic t_collision();
        otp_key = 0; por();
        load(2'd0, 0, 0);
        @(negedge clk);
        req_valid = 1; req_kind = 2'd2; req_enc = 0; prog_pin = 1;
        @(negedge clk);
        req_valid = 0; prog_pin = 0;
        chk("R13 request rejected", reject, 1);
        chk("R13 done cleared", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain_path();
        t_enc_path();
        t_program_paths();
        t_mismatch_fb();
        t_mismatch_hold();
        t_lock();
        t_key_status();
        t_collision();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule